// File: doc/BRIEF.md
# Branch Target Byte Cache

This block sits beside the fetch stage and is looked up with the fetch address of a branch. Each entry holds the first sixteen instruction bytes found at that branch's destination. It does not hold the destination address, which other logic computes during decode. When the direction predictor flags the branch as predicted taken and the entry matches, the bytes go to the decoders in the same cycle. This removes the one-clock bubble that a fresh instruction cache fetch of the destination would otherwise cost.

The structure is direct-mapped. Bit 0 of the branch address is not used. The next `$clog2(ENTRIES)` bits select the entry, and the remaining upper bits form the stored tag. After a taken branch resolves, the pipeline writes the destination bytes through the fill port. A single invalidate-all input empties the whole structure, for example after code is modified.

Top module: `tgt_byte_cache`

## Requirements
- R1: For the first cycles after the synchronous active-low reset is released, every lookup misses (`lk_hit`=0), whatever address is presented.
- R2: While `lk_taken` is 0, `lk_hit` is 0 and `lk_bytes` is all zeros, even for an address that matches a valid entry. On any miss, `lk_bytes` is also all zeros.
- R3: A fill of address A with bytes B on a clock edge makes every later lookup of A with `lk_taken`=1 return `lk_hit`=1 and `lk_bytes`=B, starting the cycle after that edge. Byte k of the destination stream sits at bits [8k+7:8k].
- R4: With the default sizes, the entry index is address bits [6:1] and the tag is bits [31:7]. A lookup whose index matches a valid entry but whose tag differs misses.
- R5: Address bit 0 takes no part in the match. Two addresses that differ only in bit 0 return the same hit and bytes.
- R6: A fill to an index that already holds a valid entry replaces it. The old tag misses from the next cycle on.
- R7: When a fill and a lookup target the same index in the same cycle, the lookup returns the contents held before that fill.
- R8: An `inv_all` pulse empties every entry in one cycle. Every lookup in the next cycle misses.
- R9: When `inv_all` and a fill coincide, the invalidation wins and the filled entry is not valid afterwards.
- R10: A fill changes only the entry it indexes. Every other entry keeps its hit status and bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | ADDR_W (32) | Fetch address of the branch being looked up |
| lk_taken | input | 1 | Direction predictor says taken; gates the hit |
| lk_hit | output | 1 | Entry matches and branch predicted taken |
| lk_bytes | output | 8*BLK_BYTES (128) | First destination bytes, byte 0 in the low bits; zero on miss |
| fl_en | input | 1 | Write one entry on this edge |
| fl_addr | input | ADDR_W (32) | Branch address whose entry is written |
| fl_bytes | input | 8*BLK_BYTES (128) | Destination bytes to store |
| inv_all | input | 1 | Clear every valid flag; overrides a coincident fill |

## Verification
The lookup path is combinational from stored state, so any corrupted valid flag, tag or byte lane shows at `lk_hit`/`lk_bytes` in the very cycle its index is presented. A stale entry shows as a hit where a miss was due, and a lost fill shows as a miss on the next cycle. The bench therefore sweeps every index after each state change: after reset, after a full fill, after partial overwrites and after invalidation. An error in one entry then shows up no later than one pass of 64 lookups. Cross-entry disturbance, bit-0 aliasing and write-versus-read ordering within one cycle are each probed on their own.

// File: rtl/tbc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the branch target byte cache.
// Assumes: bytes are 8 bits; entries are written whole, never partially.
package tbc_pkg;

    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned DEF_BLK_BYTES = 16;

    // Per-entry action decided for the coming clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_FILL  = 2'd1,
        OP_CLEAR = 2'd2
    } tbc_op_e;

endpackage

// File: rtl/tbc_addr_split.sv
`timescale 1ns/1ps
// Splits a branch address into entry index and tag.
// Assumes: bit 0 is ignored; index sits directly above it, tag above that.
module tbc_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 6,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    logic unused_lsb;

    // Field extraction.
    always_comb begin
        idx = addr[IDX_W:1];
        tag = addr[ADDR_W-1:IDX_W+1];
    end

    assign unused_lsb = addr[0];

endmodule

// File: rtl/tbc_wr_ctrl.sv
`timescale 1ns/1ps
// Decides, per entry, whether the next edge holds, fills or clears it.
// Assumes: invalidate-all overrides a fill in the same cycle.
module tbc_wr_ctrl
    import tbc_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             inv_all,
    output tbc_op_e          op [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_op
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        // Priority: clear, then fill of this index, else hold.
        always_comb begin
            if (inv_all) begin
                op[g] = OP_CLEAR;
            end else if (fill_en && (fill_idx == MY_IDX)) begin
                op[g] = OP_FILL;
            end else begin
                op[g] = OP_HOLD;
            end
        end
    end

endmodule

// File: rtl/tbc_entry.sv
`timescale 1ns/1ps
// One storage entry: valid flag, tag and destination bytes.
// Assumes: only the valid flag needs reset; tag/data are qualified by it.
module tbc_entry
    import tbc_pkg::*;
#(
    parameter int unsigned TAG_W = 25,
    parameter int unsigned BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tbc_op_e          op,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_data,
    output logic             valid,
    output logic [TAG_W-1:0] tag,
    output logic [BLK_W-1:0] data
);

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic [BLK_W-1:0] data_q;

    // Valid flag: cleared by reset or invalidate, set by fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            case (op)
                OP_CLEAR: valid_q <= 1'b0;
                OP_FILL:  valid_q <= 1'b1;
                default:  valid_q <= valid_q;
            endcase
        end
    end

    // Payload capture on fill.
    always_ff @(posedge clk) begin
        if (op == OP_FILL) begin
            tag_q  <= wr_tag;
            data_q <= wr_data;
        end
    end

    assign valid = valid_q;
    assign tag   = tag_q;
    assign data  = data_q;

endmodule

// File: rtl/tbc_read_sel.sv
`timescale 1ns/1ps
// Combinational lookup: selects the indexed entry, compares the tag,
// gates by predicted-taken and zeroes the bytes on a miss.
// Assumes: storage is read before the edge, so same-cycle fills are not seen.
module tbc_read_sel #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 25,
    parameter int unsigned BLK_W   = 128,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_taken,
    input  logic             ent_valid [ENTRIES],
    input  logic [TAG_W-1:0] ent_tag   [ENTRIES],
    input  logic [BLK_W-1:0] ent_data  [ENTRIES],
    output logic             hit,
    output logic [BLK_W-1:0] bytes_out
);

    logic             sel_valid;
    logic [TAG_W-1:0] sel_tag;
    logic [BLK_W-1:0] sel_data;
    logic             tag_eq;

    // Entry selection by index.
    always_comb begin
        sel_valid = ent_valid[lk_idx];
        sel_tag   = ent_tag[lk_idx];
        sel_data  = ent_data[lk_idx];
    end

    // Match, gating and output zeroing.
    always_comb begin
        tag_eq    = (sel_tag == lk_tag);
        hit       = lk_taken && sel_valid && tag_eq;
        bytes_out = hit ? sel_data : '0;
    end

endmodule

// File: rtl/tgt_byte_cache.sv
`timescale 1ns/1ps
// Branch target byte cache: direct-mapped store of the first destination
// bytes of taken branches, read combinationally in the lookup cycle.
// Assumes: ENTRIES is a power of two; the caller fills only after the
// branch resolved taken; destination address arithmetic lives elsewhere.
module tgt_byte_cache
    import tbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ENTRIES   = 64,
    parameter int unsigned BLK_BYTES = DEF_BLK_BYTES,
    localparam int unsigned IDX_W    = $clog2(ENTRIES),
    localparam int unsigned TAG_W    = ADDR_W - IDX_W - 1,
    localparam int unsigned BLK_W    = BLK_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_taken,
    output logic              lk_hit,
    output logic [BLK_W-1:0]  lk_bytes,
    input  logic              fl_en,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [BLK_W-1:0]  fl_bytes,
    input  logic              inv_all
);

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] fl_idx;
    logic [TAG_W-1:0] fl_tag;
    tbc_op_e          ent_op    [ENTRIES];
    logic             ent_valid [ENTRIES];
    logic [TAG_W-1:0] ent_tag   [ENTRIES];
    logic [BLK_W-1:0] ent_data  [ENTRIES];

    tbc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) lk_split_i (
        .addr (lk_addr),
        .idx  (lk_idx),
        .tag  (lk_tag)
    );

    tbc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fl_split_i (
        .addr (fl_addr),
        .idx  (fl_idx),
        .tag  (fl_tag)
    );

    tbc_wr_ctrl #(.ENTRIES(ENTRIES)) wr_ctrl_i (
        .fill_en  (fl_en),
        .fill_idx (fl_idx),
        .inv_all  (inv_all),
        .op       (ent_op)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        tbc_entry #(.TAG_W(TAG_W), .BLK_W(BLK_W)) entry_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (ent_op[e]),
            .wr_tag  (fl_tag),
            .wr_data (fl_bytes),
            .valid   (ent_valid[e]),
            .tag     (ent_tag[e]),
            .data    (ent_data[e])
        );
    end

    tbc_read_sel #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W)) read_i (
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .lk_taken  (lk_taken),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_data  (ent_data),
        .hit       (lk_hit),
        .bytes_out (lk_bytes)
    );

endmodule

// File: rtl/tgt_byte_cache_chk.sv
`timescale 1ns/1ps
// Port-level temporal checks for the branch target byte cache.
// Assumes: bound to every instance of tgt_byte_cache.
module tgt_byte_cache_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BLK_W  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_taken,
    input logic              lk_hit,
    input logic [BLK_W-1:0]  lk_bytes,
    input logic              fl_en,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [BLK_W-1:0]  fl_bytes,
    input logic              inv_all
);

    // R1
    after_reset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // R2
    not_taken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_taken |-> (!lk_hit && lk_bytes == '0));

    // R3
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fl_en) && !$past(inv_all) && lk_taken &&
         lk_addr[ADDR_W-1:1] == $past(fl_addr[ADDR_W-1:1]))
        |-> (lk_hit && lk_bytes == $past(fl_bytes)));

    // R8
    inv_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_all) |-> !lk_hit);

    // R10
    hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && $past(lk_hit) && $stable(lk_addr) &&
         !$past(fl_en) && !$past(inv_all)) |-> $stable(lk_bytes));

endmodule

bind tgt_byte_cache tgt_byte_cache_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_i (.*);

// File: tb/tgt_byte_cache_tb_top.sv
`timescale 1ns/1ps
// Sweep bench for tgt_byte_cache with default sizes (64 entries, 32-bit).
module tgt_byte_cache_tb_top;

    localparam int AW = 32;
    localparam int IW = 6;
    localparam int TW = AW - IW - 1;
    localparam int NE = 64;
    localparam int BW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_taken = 1'b0;
    logic          lk_hit;
    logic [BW-1:0] lk_bytes;
    logic          fl_en = 1'b0;
    logic [AW-1:0] fl_addr = '0;
    logic [BW-1:0] fl_bytes = '0;
    logic          inv_all = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic          m_valid [NE];
    logic [TW-1:0] m_tag   [NE];
    logic [BW-1:0] m_data  [NE];

    always #10 clk = ~clk;

    tgt_byte_cache #(.ADDR_W(AW), .ENTRIES(NE), .BLK_BYTES(16)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (lk_addr),
        .lk_taken (lk_taken),
        .lk_hit   (lk_hit),
        .lk_bytes (lk_bytes),
        .fl_en    (fl_en),
        .fl_addr  (fl_addr),
        .fl_bytes (fl_bytes),
        .inv_all  (inv_all)
    );

    function automatic logic [BW-1:0] mk_data(int idx, logic [TW-1:0] tg, int salt);
        logic [BW-1:0] d;
        for (int k = 0; k < 16; k++) d[k*8 +: 8] = 8'(idx * 16 + k + int'(tg) * 3 + salt);
        return d;
    endfunction

    function automatic logic [TW-1:0] mk_tag(int idx, int salt);
        return TW'(idx * 40503 + salt * 977 + 11);
    endfunction

    // Write one entry through the fill port; model follows the edge.
    task automatic fill_one(int idx, logic [TW-1:0] tg, logic [BW-1:0] d);
        @(negedge clk);
        fl_en = 1'b1; fl_addr = {tg, IW'(idx), 1'b1}; fl_bytes = d;
        @(posedge clk); #1;
        fl_en = 1'b0;
        m_valid[idx] = 1'b1; m_tag[idx] = tg; m_data[idx] = d;
    endtask

    // Present a lookup and compare against the model.
    task automatic probe(int idx, logic [TW-1:0] tg, logic b0, logic tk, string req);
        logic          eh;
        logic [BW-1:0] eb;
        @(negedge clk);
        lk_addr = {tg, IW'(idx), b0}; lk_taken = tk;
        #1;
        eh = tk && m_valid[idx] && (m_tag[idx] == tg);
        eb = eh ? m_data[idx] : '0;
        checks++;
        if (lk_hit !== eh || lk_bytes !== eb) begin
            fails++;
            $display("FAIL %s idx=%0d hit=%b exp=%b bytes=%h exp=%h",
                     req, idx, lk_hit, eh, lk_bytes, eb);
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired hit=%b exp=done", lk_hit);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [TW-1:0] t;
        logic [BW-1:0] d;
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: nothing hits after reset
        for (int i = 0; i < NE; i++) probe(i, mk_tag(i, 0), 1'b0, 1'b1, "R1");

        // R3: fill every index, then sweep
        for (int i = 0; i < NE; i++) fill_one(i, mk_tag(i, 0), mk_data(i, mk_tag(i, 0), 0));
        for (int i = 0; i < NE; i++) begin
            probe(i, mk_tag(i, 0), 1'b0, 1'b1, "R3");
            probe(i, mk_tag(i, 0), 1'b0, 1'b0, "R2");
            probe(i, mk_tag(i, 0), 1'b1, 1'b1, "R5");
            probe(i, mk_tag(i, 0) ^ TW'(1 << (i % TW)), 1'b0, 1'b1, "R4");
        end

        // R6 / R10: overwrite even indices with new tags
        for (int i = 0; i < NE; i += 2) fill_one(i, mk_tag(i, 1), mk_data(i, mk_tag(i, 1), 5));
        for (int i = 0; i < NE; i++) begin
            if (i % 2 == 0) begin
                probe(i, mk_tag(i, 0), 1'b0, 1'b1, "R6");
                probe(i, mk_tag(i, 1), 1'b0, 1'b1, "R6");
            end else begin
                probe(i, mk_tag(i, 0), 1'b0, 1'b1, "R10");
            end
        end

        // R7: fill and lookup of index 3 in the same cycle
        t = mk_tag(3, 2);
        d = mk_data(3, t, 9);
        @(negedge clk);
        fl_en = 1'b1; fl_addr = {t, IW'(3), 1'b0}; fl_bytes = d;
        lk_addr = {m_tag[3], IW'(3), 1'b0}; lk_taken = 1'b1;
        #1;
        checks++;
        if (lk_hit !== 1'b1 || lk_bytes !== m_data[3]) begin
            fails++;
            $display("FAIL R7 hit=%b exp=1 bytes=%h exp=%h", lk_hit, lk_bytes, m_data[3]);
        end
        @(posedge clk); #1;
        fl_en = 1'b0;
        m_tag[3] = t; m_data[3] = d;
        probe(3, t, 1'b0, 1'b1, "R3");
        probe(2, mk_tag(2, 1), 1'b0, 1'b1, "R10");

        // R8 / R9: invalidate-all together with a fill of index 5
        t = mk_tag(5, 3);
        @(negedge clk);
        inv_all = 1'b1; fl_en = 1'b1; fl_addr = {t, IW'(5), 1'b0}; fl_bytes = mk_data(5, t, 1);
        @(posedge clk); #1;
        inv_all = 1'b0; fl_en = 1'b0;
        for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
        probe(5, t, 1'b0, 1'b1, "R9");
        for (int i = 0; i < NE; i++) probe(i, m_tag[i], 1'b0, 1'b1, "R8");

        // R3: usable again after invalidation
        fill_one(9, mk_tag(9, 4), mk_data(9, mk_tag(9, 4), 2));
        probe(9, mk_tag(9, 4), 1'b1, 1'b1, "R3");
        probe(10, mk_tag(10, 0), 1'b0, 1'b1, "R10");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule